// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the transfer engine of a single DMA channel. Software loads a 32-bit control word, a source address, a destination address and a unit count in one write. Each unit is copied by reading from the source and then writing to the destination over a simple bus-master handshake. After the unit, each address steps by the unit's byte size in its own direction (fixed, up or down) and the count drops by one. When the count reaches zero a sticky transfer-end flag is set, the engine stops and, if enabled, an interrupt is raised.

Transfers are paced by an active-low external request line, sampled either as a low level or as a falling edge. An acknowledge output marks the read phase or the write phase of every bus access, with selectable polarity. In cycle-steal mode the bus is released after every unit and each unit needs its own request. In burst mode one request moves the whole count without releasing the bus.

Control word layout (bit positions): 0 enable, 1 transfer-end, 2 interrupt enable, 6:4 unit size, 7 burst, 9:8 source mode, 11:10 destination mode, 12 edge request, 13 acknowledge on write, 14 acknowledge active-low.

Top module: `dma_chan_seq`

## Requirements
- R1: The unit size field (bits 6:4) selects the per-unit address step: 000 = 8 bytes, 001 = 1, 010 = 2, 011 = 4, 100 = 32-byte block; `bus_size` carries the code.
- R2: Source mode (bits 9:8) and destination mode (bits 11:10) are independent: 00 keeps the address, 01 adds one unit's byte size, 10 subtracts it, once per completed unit.
- R3: Each unit is a read at the source followed by a write of the same data at the destination; a block unit is four such 8-byte read/write pairs at offsets 0, 8, 16, 24 from the unit's base addresses.
- R4: From reset all registers read zero and the bus is idle; the count drops by exactly one per completed unit, and transfer-end (bit 1) sets in the cycle the count reaches zero.
- R5: With bit 7 = 0 (cycle-steal) `bus_req` falls after every unit; with bit 7 = 1 (burst) it stays high from the first unit to the last.
- R6: With bit 12 = 0 a request is `dreq_n` low when the engine is idle; with bit 12 = 1 only a falling edge counts, and one edge starts exactly one cycle-steal unit even if the line then stays low.
- R7: `dack` is active while a read is on the bus (bit 13 = 0) or while a write is on the bus (bit 13 = 1); bit 14 = 0 makes it active-high, 1 active-low, and it sits at its inactive level otherwise.
- R8: `irq` is high exactly while transfer-end and interrupt enable (bit 2) are both set.
- R9: Transfer-end is sticky: a configuration write with bit 1 = 0 clears it, one with bit 1 = 1 leaves it unchanged and can never set it.
- R10: Requests arriving while enable (bit 0) is clear or while transfer-end is set start no bus activity and leave the count unchanged.
- R11: Once `bus_req` is raised, address and direction stay stable and `bus_req` stays high until `bus_gnt`.
- R12: A configuration write while the engine holds the bus is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load all four configuration values |
| cfg_ctrl | input | 32 | Control word to load |
| cfg_src | input | AW | Source address to load |
| cfg_dst | input | AW | Destination address to load |
| cfg_cnt | input | CW | Unit count to load |
| ctrl_q | output | 32 | Current control word, transfer-end included |
| src_q | output | AW | Current source address |
| dst_q | output | AW | Current destination address |
| cnt_q | output | CW | Remaining units |
| dreq_n | input | 1 | External transfer request, active low |
| dack | output | 1 | Transfer acknowledge |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_size | output | 3 | Unit size code |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid with grant |
| bus_gnt | input | 1 | Access completes this cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Randomised trials draw every combination of source mode, destination mode, unit size, burst versus cycle-steal, level versus edge request and acknowledge phase and polarity, against a memory that grants after a random zero to two cycle wait. Comparing the whole memory image against a bench copy model separates wrong step sizes and wrong directions from wrong beat offsets inside a block, and the count of `bus_req` falls tells burst from cycle-steal. Directed cases hold the request line low on a disabled or finished channel, hold it low after a single edge in edge mode, attempt to set transfer-end by writing it, and rewrite the configuration mid-burst.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_ctrl,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  output logic [31:0]   ctrl_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  input  logic          dreq_n,
  output logic          dack,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [63:0]   bus_wdata,
  input  logic [63:0]   bus_rdata,
  input  logic          bus_gnt,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;
  logic [1:0]    beat;
  logic [63:0]   hold;
  logic          dreq_d, pend;
  logic [AW-1:0] step;

  wire       en     = ctrl_q[0];
  wire       te     = ctrl_q[1];
  wire       ie     = ctrl_q[2];
  wire [2:0] size   = ctrl_q[6:4];
  wire       burst  = ctrl_q[7];
  wire [1:0] smode  = ctrl_q[9:8];
  wire [1:0] dmode  = ctrl_q[11:10];
  wire       edge_m = ctrl_q[12];
  wire       ack_wr = ctrl_q[13];
  wire       ack_lo = ctrl_q[14];

  always_comb begin
    case (size)
      3'd0:    step = AW'(8);
      3'd1:    step = AW'(1);
      3'd2:    step = AW'(2);
      3'd3:    step = AW'(4);
      3'd4:    step = AW'(32);
      default: step = AW'(1);
    endcase
  end

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] m,
                                        input logic [AW-1:0] s);
    case (m)
      2'b01:   adv = a + s;
      2'b10:   adv = a - s;
      default: adv = a;
    endcase
  endfunction

  wire [1:0]    last_beat = (size == 3'd4) ? 2'd3 : 2'd0;
  wire          armed     = en && !te && (cnt_q != '0);
  wire          fall      = dreq_d && !dreq_n;
  wire          want      = edge_m ? pend : !dreq_n;
  wire          cfg_ok    = cfg_we && (st == S_IDLE);
  wire          start     = (st == S_IDLE) && armed && want && !cfg_we;
  wire [AW-1:0] off       = AW'({beat, 3'b000});

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? dst_q + off : src_q + off;
  assign bus_size  = size;
  assign bus_wdata = hold;
  assign dack      = (((st == S_RD) && !ack_wr) || ((st == S_WR) && ack_wr)) ^ ack_lo;
  assign irq       = te && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_d <= 1'b1;
      pend   <= 1'b0;
    end else begin
      dreq_d <= dreq_n;
      if (!armed || cfg_ok)     pend <= 1'b0;
      else if (fall && edge_m)  pend <= 1'b1;
      else if (start)           pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      beat   <= '0;
      hold   <= '0;
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_ok) begin
            ctrl_q <= {cfg_ctrl[31:2], cfg_ctrl[1] & te, cfg_ctrl[0]};
            src_q  <= cfg_src;
            dst_q  <= cfg_dst;
            cnt_q  <= cfg_cnt;
          end else if (start) begin
            st   <= S_RD;
            beat <= '0;
          end
        end
        S_RD: begin
          if (bus_gnt) begin
            hold <= bus_rdata;
            st   <= S_WR;
          end
        end
        default: begin
          if (bus_gnt) begin
            if (beat != last_beat) begin
              beat <= beat + 2'd1;
              st   <= S_RD;
            end else begin
              beat  <= '0;
              src_q <= adv(src_q, smode, step);
              dst_q <= adv(dst_q, dmode, step);
              cnt_q <= cnt_q - CW'(1);
              if (cnt_q == CW'(1)) begin
                ctrl_q[1] <= 1'b1;
                st        <= S_IDLE;
              end else begin
                st <= burst ? S_RD : S_IDLE;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          en,
  input logic          te,
  input logic          ack_lo,
  input logic [CW-1:0] cnt_q,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_gnt,
  input logic [AW-1:0] bus_addr,
  input logic          dack
);
  AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R11
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_we |=> bus_req && bus_we); // R3
  AST_COUNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) && (cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) - CW'(1)); // R4
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te) |-> cnt_q == '0); // R4
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    te && !cfg_we |=> te); // R9
  AST_END_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    te |-> !bus_req); // R10
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !bus_req |=> !bus_req); // R10
  AST_ACK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> dack == ack_lo); // R7
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .en(ctrl_q[0]), .te(ctrl_q[1]),
  .ack_lo(ctrl_q[14]), .cnt_q(cnt_q), .bus_req(bus_req), .bus_we(bus_we),
  .bus_gnt(bus_gnt), .bus_addr(bus_addr), .dack(dack)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
  localparam int AW = 32;
  localparam int CW = 24;
  localparam int MSZ = 2048;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [31:0] cfg_ctrl = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [31:0] ctrl_q;
  logic [AW-1:0] src_q, dst_q, bus_addr;
  logic [CW-1:0] cnt_q;
  logic dreq_n = 1, dack, bus_req, bus_we, irq, bus_gnt = 0;
  logic [2:0] bus_size;
  logic [63:0] bus_wdata, bus_rdata = '0;

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] exp_m [0:MSZ-1];
  int checks = 0, fails = 0;
  int falls = 0, req_cycles = 0, dack_err = 0;

  always #2.5 clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW)) uut (.*);

  function automatic int ubytes(input logic [2:0] sz);
    case (sz)
      3'd1: return 1; 3'd2: return 2; 3'd3: return 4; 3'd4: return 32;
      default: return 8;
    endcase
  endfunction

  function automatic int beat_bytes(input logic [2:0] sz);
    return (sz == 3'd4 || sz == 3'd0) ? 8 : ubytes(sz);
  endfunction

  function automatic int delta(input logic [1:0] m, input logic [2:0] sz);
    return (m == 2'b01) ? ubytes(sz) : (m == 2'b10) ? -ubytes(sz) : 0;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit en, te, ie, input logic [2:0] sz,
      input bit bst, input logic [1:0] sm, dm, input bit edg, aw, al);
    return {17'd0, al, aw, edg, dm, sm, bst, sz, 1'b0, ie, te, en};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic mem_loop();
    int wt = 0;
    forever begin
      @(negedge clk);
      if (bus_req && wt == 0) begin
        for (int i = 0; i < beat_bytes(bus_size); i++) begin
          if (bus_we) mem[(bus_addr + i) % MSZ] = bus_wdata[8*i +: 8];
          else        bus_rdata[8*i +: 8] = mem[(bus_addr + i) % MSZ];
        end
        bus_gnt = 1;
        wt = $urandom_range(0, 2);
      end else begin
        bus_gnt = 0;
        if (wt > 0) wt--;
      end
    end
  endtask

  task automatic mon_loop();
    logic prev = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (dack !== ((bus_req && (bus_we == ctrl_q[13])) ^ ctrl_q[14])) dack_err++;
        if (prev && !bus_req) falls++;
        if (bus_req) req_cycles++;
        prev = bus_req;
      end
    end
  endtask

  task automatic clr_mon();
    falls = 0; req_cycles = 0; dack_err = 0;
  endtask

  task automatic cfg(input logic [31:0] c, input logic [AW-1:0] s, d, input int n);
    @(negedge clk);
    cfg_we = 1; cfg_ctrl = c; cfg_src = s; cfg_dst = d; cfg_cnt = CW'(n);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'($urandom);
      exp_m[i] = mem[i];
    end
  endtask

  task automatic wait_te(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (ctrl_q[1]) begin ok = 1; break; end
    end
  endtask

  task automatic pulse();
    @(negedge clk); dreq_n = 0;
    @(negedge clk); dreq_n = 1;
  endtask

  task automatic trial(input logic [1:0] sm, dm, input logic [2:0] sz,
                       input bit bst, edg, aw, al, ie, input int n);
    logic [AW-1:0] s0 = 32'h200, d0 = 32'h600;
    bit ok;
    int bad = 0;
    fill_mem();
    for (int u = 0; u < n; u++) begin
      int s = int'(s0) + u * delta(sm, sz);
      int d = int'(d0) + u * delta(dm, sz);
      for (int b = 0; b < ((sz == 3'd4) ? 4 : 1); b++)
        for (int i = 0; i < beat_bytes(sz); i++)
          exp_m[(d + 8*b + i) % MSZ] = exp_m[(s + 8*b + i) % MSZ];
    end
    cfg(mk_ctrl(1, 0, ie, sz, bst, sm, dm, edg, aw, al), s0, d0, n);
    clr_mon();
    if (!edg) begin
      dreq_n = 0;
      wait_te(3000, ok);
      dreq_n = 1;
    end else begin
      ok = 0;
      for (int k = 0; k < 200 && !ctrl_q[1]; k++) begin
        pulse();
        repeat (3) @(negedge clk);
      end
      wait_te(3000, ok);
    end
    repeat (3) @(negedge clk);
    chk(ok && ctrl_q[1], "R4", "transfer-end set", ctrl_q[1], 1);
    chk(cnt_q == 0, "R4", "count exhausted", cnt_q, 0);
    chk(src_q == AW'(int'(s0) + n * delta(sm, sz)), "R1 R2", "final source", src_q,
        AW'(int'(s0) + n * delta(sm, sz)));
    chk(dst_q == AW'(int'(d0) + n * delta(dm, sz)), "R1 R2", "final destination", dst_q,
        AW'(int'(d0) + n * delta(dm, sz)));
    for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_m[i]) bad++;
    chk(bad == 0, "R3", "memory bytes differing", bad, 0);
    chk(irq == ie, "R8", "irq level", irq, ie);
    chk(dack_err == 0, "R7", "acknowledge mismatched cycles", dack_err, 0);
    chk(falls == (bst ? 1 : n), "R5", "bus release count", falls, bst ? 1 : n);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'h5eed_0dd1));
    fork
      mem_loop();
      mon_loop();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    chk(ctrl_q == 0 && cnt_q == 0 && src_q == 0 && dst_q == 0, "R4", "reset registers",
        ctrl_q, 0);
    chk(!bus_req && !irq && !dack, "R4", "reset outputs", {bus_req, irq, dack}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed corner cases of the main function
    trial(2'b01, 2'b01, 3'd4, 0, 0, 0, 0, 1, 3);
    trial(2'b10, 2'b00, 3'd1, 1, 1, 1, 1, 0, 5);
    trial(2'b00, 2'b10, 3'd0, 1, 0, 1, 0, 1, 4);

    // R9 / R10: request with transfer-end set, write that keeps it
    fill_mem();
    cfg(mk_ctrl(1, 1, 0, 3'd3, 0, 2'b01, 2'b01, 0, 0, 0), 32'h200, 32'h600, 2);
    chk(ctrl_q[1] == 1, "R9", "transfer-end kept by write of 1", ctrl_q[1], 1);
    clr_mon();
    dreq_n = 0;
    repeat (20) @(negedge clk);
    chk(cnt_q == 2 && req_cycles == 0, "R10", "no transfer while ended", cnt_q, 2);
    cfg(mk_ctrl(1, 0, 0, 3'd3, 0, 2'b01, 2'b01, 0, 0, 0), 32'h200, 32'h600, 2);
    wait_te(500, ok);
    dreq_n = 1;
    chk(ok && cnt_q == 0, "R9", "clear by write of 0 resumes", cnt_q, 0);

    // R10: disabled channel
    cfg(mk_ctrl(0, 0, 0, 3'd1, 0, 2'b01, 2'b01, 0, 0, 0), 32'h200, 32'h600, 3);
    clr_mon();
    dreq_n = 0;
    repeat (20) @(negedge clk);
    dreq_n = 1;
    chk(cnt_q == 3 && req_cycles == 0, "R10", "no transfer while disabled", cnt_q, 3);

    // R9: software cannot set transfer-end
    cfg(mk_ctrl(0, 1, 1, 3'd1, 0, 2'b00, 2'b00, 0, 0, 0), 32'h200, 32'h600, 3);
    chk(ctrl_q[1] == 0 && irq == 0, "R9", "write of 1 does not set", ctrl_q[1], 0);

    // R6: one edge, one unit
    cfg(mk_ctrl(1, 0, 0, 3'd1, 0, 2'b01, 2'b01, 1, 0, 0), 32'h200, 32'h600, 4);
    pulse();
    repeat (40) @(negedge clk);
    chk(cnt_q == 3, "R6", "single edge moves one unit", cnt_q, 3);
    @(negedge clk); dreq_n = 0;
    repeat (40) @(negedge clk);
    chk(cnt_q == 2, "R6", "held low after edge moves one unit", cnt_q, 2);
    dreq_n = 1;

    // R12: configuration write during a burst
    fill_mem();
    cfg(mk_ctrl(1, 0, 0, 3'd4, 1, 2'b01, 2'b10, 0, 0, 0), 32'h200, 32'h600, 3);
    dreq_n = 0;
    for (int i = 0; i < 50 && !bus_req; i++) @(negedge clk);
    dreq_n = 1;
    repeat (5) @(negedge clk);
    cfg(mk_ctrl(1, 0, 0, 3'd1, 0, 2'b00, 2'b00, 0, 0, 0), 32'h100, 32'h100, 9);
    wait_te(2000, ok);
    chk(ok && src_q == 32'h260 && dst_q == 32'h5A0, "R12", "mid-burst write ignored",
        src_q, 32'h260);

    // constrained random trials
    for (int t = 0; t < 24; t++)
      trial(2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)), 3'($urandom_range(0, 4)),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(1, 5));

    summary();
    $finish;
  end
endmodule